// File: doc/BRIEF.md
# Status Flag Reporting Policy Controller

This block keeps the fault-related bits of a 1553 remote-terminal status word and the three fault bits of the built-in-test word. Fault events from the rest of the terminal are latched here. A decoded command strobe, together with the mode-command identity and its 5-bit code, decides at each command which flags go into the reply and whether the latches are cleared. Four static option straps (active low) choose the reporting policy:

- With the enable strap high, the standard behaviour applies.
- With the enable strap low, the other three straps select: clear on every command, report in a status query, report in the next reply, and keep the fault bits across a test-word query.

The reply bits are registered. They change on the clock edge that accepts a command and hold until the next command. The built-in-test bits show the live latch contents.

A finite-state machine tracks where the latched fault stands. The states are:

- ST_CLEAN: nothing is latched.
- ST_FRESH: a fault has arrived and no clearing command has followed it.
- ST_SHOWN: the fault has been placed in a next-status reply.

The transitions are:

- CLEAN or SHOWN to FRESH on any fault event.
- FRESH to SHOWN when the next-status policy reports the flags.
- FRESH or SHOWN to CLEAN on a clearing command that arrives with no concurrent fault.
- Any state to CLEAN on the Reset Remote Terminal mode command.

A separate window timer sets the message-error bit. It does so when the subsystem raises its request within a programmable number of cycles after the in-command signal falls.

Top module: `stflag_policy`

## Requirements
- R1: After rst_n is asserted, every output is 0.
- R2: The terminal-flag cause is the OR of lt_fail, tx_timeout, selftest_fail and addr_par_err. The subsystem-flag cause is ss_err_n low or hs_fail high. A cause latches on the clock edge that samples it. bw_txto, bw_hsf and bw_ltf latch tx_timeout, hs_fail and lt_fail respectively and are visible from the next cycle.
- R3: A mode command with code 01000 clears every latch, both reply flags, the built-in-test bits and the terminal-flag inhibit.
- R4: The mode command with code 00110 forces sw_tf to 0 until the mode command with code 00111 or the 01000 reset is accepted.
- R5: With pol_en_n high, the other straps have no effect. Every command replies with the latched flags OR'd with the live causes. A non-query command then reloads the latches with the live causes only, so a persisting cause stays reported and an ended cause is reported once more.
- R6: With pol_en_n low and the other straps high, a non-query command replies with the live causes only and clears the latches. A query (mode code 00010 or 10010) repeats the previous reply unchanged.
- R7: With pol_upd_n low, a query that follows a fault with no clearing command between them replies with the latched flags. Repeated queries keep doing so, and the next non-query command clears.
- R8: With pol_next_n low, the first non-query command after a fault replies with the latched flags and keeps them. The next non-query command clears them. Queries in between repeat the previous reply.
- R9: With pol_bitkeep_n low, a mode command 10011 that follows a fault keeps all latches, including after intervening queries. Any other non-query command clears them. With pol_bitkeep_n high, 10011 clears like any other command.
- R10: sw_me goes to 1 if merr_req rises on one of the ME_WIN_CYC sampling edges after the edge that first samples incmd_n low. A later rise has no effect, and each new fall of incmd_n clears sw_me.
- R11: On each command, sw_dbca takes the inverse of dbc_acc_n.
- R12: sw_tf, sw_ssf and sw_dbca change only on the edge that accepts a command. Fault events between commands leave them unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-up reset, active low |
| cmd_valid | input | 1 | One-cycle strobe for a valid command to this terminal |
| cmd_is_mode | input | 1 | The command is a mode command |
| cmd_code | input | 5 | Mode code, meaningful when cmd_is_mode is high |
| ss_err_n | input | 1 | Subsystem error, active low |
| hs_fail | input | 1 | Handshake failure event |
| lt_fail | input | 1 | Loop-test failure event |
| tx_timeout | input | 1 | Transmitter timeout event |
| selftest_fail | input | 1 | Self-test failure event |
| addr_par_err | input | 1 | Terminal address parity error |
| pol_en_n | input | 1 | Enables the alternative policies when low |
| pol_upd_n | input | 1 | Report in status queries when low |
| pol_next_n | input | 1 | Report in the next reply when low |
| pol_bitkeep_n | input | 1 | Keep the latches across a test-word query when low |
| incmd_n | input | 1 | In-command indication, active low |
| merr_req | input | 1 | Message-error request from the subsystem |
| dbc_acc_n | input | 1 | Bus-control acceptance, active low |
| sw_tf | output | 1 | Status reply terminal flag |
| sw_ssf | output | 1 | Status reply subsystem flag |
| sw_me | output | 1 | Status reply message error |
| sw_dbca | output | 1 | Status reply bus-control accepted |
| bw_txto | output | 1 | Built-in-test word transmitter timeout |
| bw_hsf | output | 1 | Built-in-test word handshake failure |
| bw_ltf | output | 1 | Built-in-test word loop-test failure |

## Verification
A wrong policy state shows up no later than the second command after a fault. A state stuck in FRESH makes a clearing command keep the fault bits or reply with stale flags. A state that reaches CLEAN too early loses the flag from a query or next-status reply. The bench's behavioural model compares all seven outputs on every clock. A latching or inhibit error therefore appears one cycle after the offending edge, and a message-error window off by one cycle appears on the edge cases of the window.

// File: rtl/stflag_pkg.sv
package stflag_pkg;

    localparam int CODE_W = 5;
    localparam int BIT_N  = 3;

    localparam logic [CODE_W-1:0] MC_TXSTAT = 5'b00010;
    localparam logic [CODE_W-1:0] MC_INH    = 5'b00110;
    localparam logic [CODE_W-1:0] MC_UNINH  = 5'b00111;
    localparam logic [CODE_W-1:0] MC_RESET  = 5'b01000;
    localparam logic [CODE_W-1:0] MC_TXLAST = 5'b10010;
    localparam logic [CODE_W-1:0] MC_TXBIT  = 5'b10011;

    typedef enum logic [1:0] {
        ST_CLEAN,
        ST_FRESH,
        ST_SHOWN
    } flag_st_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_RESET,
        ACT_HOLD,
        ACT_SHOW,
        ACT_MARK,
        ACT_CLEAR,
        ACT_LEGACY
    } act_e;

endpackage

// File: rtl/stflag_merr_window.sv
module stflag_merr_window #(
    parameter int WIN_CYC = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic incmd_n,
    input  logic merr_req,
    output logic me_o
);
    localparam int CW = $clog2(WIN_CYC + 1);

    logic          inc_prev;
    logic          merr_prev;
    logic [CW-1:0] cnt_q;
    logic          me_q;
    logic          fall;
    logic          rise;

    assign fall = inc_prev & ~incmd_n;
    assign rise = ~merr_prev & merr_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inc_prev  <= 1'b1;
            merr_prev <= 1'b0;
            cnt_q     <= '0;
            me_q      <= 1'b0;
        end else begin
            inc_prev  <= incmd_n;
            merr_prev <= merr_req;
            if (fall) begin
                cnt_q <= CW'(WIN_CYC);
                me_q  <= 1'b0;
            end else begin
                if (cnt_q != '0) cnt_q <= cnt_q - CW'(1);
                if (rise && (cnt_q != '0)) me_q <= 1'b1;
            end
        end
    end

    assign me_o = me_q;

    // R10
    me_needs_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(me_q) |-> $past(cnt_q != '0));

    // R10
    me_cleared_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_prev && !incmd_n) |=> !me_q);

endmodule

// File: rtl/stflag_policy_fsm.sv
module stflag_policy_fsm
    import stflag_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              live_tf,
    input  logic              live_ssf,
    input  logic [BIT_N-1:0]  live_bits,
    input  logic              pol_en_n,
    input  logic              pol_upd_n,
    input  logic              pol_next_n,
    input  logic              pol_bitkeep_n,
    input  logic              dbc_acc_n,
    output logic              rep_tf,
    output logic              rep_ssf,
    output logic              rep_dbca,
    output logic              inh_tf,
    output logic [BIT_N-1:0]  bits_o
);
    flag_st_e          st_q, st_d;
    act_e              act;
    logic              tf_q, ssf_q;
    logic [BIT_N-1:0]  bits_q;
    logic              is_query, is_bit, is_rst, is_inh, is_uninh;
    logic              evt;
    logic              lat_tf, lat_ssf;
    logic [BIT_N-1:0]  lat_bits;

    assign is_query = cmd_is_mode && (cmd_code == MC_TXSTAT || cmd_code == MC_TXLAST);
    assign is_bit   = cmd_is_mode && (cmd_code == MC_TXBIT);
    assign is_rst   = cmd_is_mode && (cmd_code == MC_RESET);
    assign is_inh   = cmd_is_mode && (cmd_code == MC_INH);
    assign is_uninh = cmd_is_mode && (cmd_code == MC_UNINH);

    assign evt      = live_tf | live_ssf | (|live_bits);
    assign lat_tf   = tf_q | live_tf;
    assign lat_ssf  = ssf_q | live_ssf;
    assign lat_bits = bits_q | live_bits;

    // command classification
    always_comb begin
        act = ACT_NONE;
        if (cmd_valid) begin
            if (is_rst)
                act = ACT_RESET;
            else if (pol_en_n)
                act = is_query ? ACT_SHOW : ACT_LEGACY;
            else if (is_query)
                act = (!pol_upd_n && st_q == ST_FRESH) ? ACT_SHOW : ACT_HOLD;
            else if (is_bit && !pol_bitkeep_n && st_q == ST_FRESH)
                act = ACT_SHOW;
            else if (!pol_next_n && st_q == ST_FRESH)
                act = ACT_MARK;
            else
                act = ACT_CLEAR;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (act)
            ACT_NONE, ACT_HOLD, ACT_SHOW: st_d = evt ? ST_FRESH : st_q;
            ACT_MARK:                     st_d = evt ? ST_FRESH : ST_SHOWN;
            ACT_CLEAR, ACT_LEGACY:        st_d = evt ? ST_FRESH : ST_CLEAN;
            ACT_RESET:                    st_d = ST_CLEAN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_CLEAN;
        else        st_q <= st_d;
    end

    // latches and reply register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tf_q    <= 1'b0;
            ssf_q   <= 1'b0;
            bits_q  <= '0;
            rep_tf  <= 1'b0;
            rep_ssf <= 1'b0;
        end else begin
            unique case (act)
                ACT_RESET: begin
                    tf_q    <= 1'b0;
                    ssf_q   <= 1'b0;
                    bits_q  <= '0;
                    rep_tf  <= 1'b0;
                    rep_ssf <= 1'b0;
                end
                ACT_NONE, ACT_HOLD: begin
                    tf_q   <= lat_tf;
                    ssf_q  <= lat_ssf;
                    bits_q <= lat_bits;
                end
                ACT_SHOW, ACT_MARK: begin
                    tf_q    <= lat_tf;
                    ssf_q   <= lat_ssf;
                    bits_q  <= lat_bits;
                    rep_tf  <= lat_tf;
                    rep_ssf <= lat_ssf;
                end
                ACT_CLEAR: begin
                    tf_q    <= live_tf;
                    ssf_q   <= live_ssf;
                    bits_q  <= live_bits;
                    rep_tf  <= live_tf;
                    rep_ssf <= live_ssf;
                end
                ACT_LEGACY: begin
                    tf_q    <= live_tf;
                    ssf_q   <= live_ssf;
                    bits_q  <= live_bits;
                    rep_tf  <= lat_tf;
                    rep_ssf <= lat_ssf;
                end
            endcase
        end
    end

    // terminal-flag inhibit and bus-control bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            inh_tf   <= 1'b0;
            rep_dbca <= 1'b0;
        end else if (cmd_valid) begin
            rep_dbca <= ~dbc_acc_n;
            if (is_rst)        inh_tf <= 1'b0;
            else if (is_inh)   inh_tf <= 1'b1;
            else if (is_uninh) inh_tf <= 1'b0;
        end
    end

    assign bits_o = bits_q;

    // R3
    reset_cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_rst) |=> (st_q == ST_CLEAN && !rep_tf && !rep_ssf
                                   && bits_q == '0 && !inh_tf));

    // R6
    query_holds_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_query && !pol_en_n && (pol_upd_n || st_q != ST_FRESH))
        |=> $stable({rep_tf, rep_ssf}));

    // R2
    ssf_cause_latches_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && live_ssf) |=> (ssf_q && st_q == ST_FRESH));

    // R9
    bitkeep_preserves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && is_bit && !pol_en_n && !pol_bitkeep_n && st_q == ST_FRESH)
        |=> ((bits_q & $past(bits_q)) == $past(bits_q)));

    // R12
    reply_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable({rep_tf, rep_ssf, rep_dbca}));

endmodule

// File: rtl/stflag_policy.sv
module stflag_policy
    import stflag_pkg::*;
#(
    parameter int ME_WIN_CYC = 125
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_is_mode,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              ss_err_n,
    input  logic              hs_fail,
    input  logic              lt_fail,
    input  logic              tx_timeout,
    input  logic              selftest_fail,
    input  logic              addr_par_err,
    input  logic              pol_en_n,
    input  logic              pol_upd_n,
    input  logic              pol_next_n,
    input  logic              pol_bitkeep_n,
    input  logic              incmd_n,
    input  logic              merr_req,
    input  logic              dbc_acc_n,
    output logic              sw_tf,
    output logic              sw_ssf,
    output logic              sw_me,
    output logic              sw_dbca,
    output logic              bw_txto,
    output logic              bw_hsf,
    output logic              bw_ltf
);
    logic             live_tf, live_ssf;
    logic [BIT_N-1:0] live_bits;
    logic             rep_tf, rep_ssf, rep_dbca, inh_tf;
    logic [BIT_N-1:0] bits_q;

    assign live_tf   = lt_fail | tx_timeout | selftest_fail | addr_par_err;
    assign live_ssf  = ~ss_err_n | hs_fail;
    assign live_bits = {tx_timeout, hs_fail, lt_fail};

    stflag_policy_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_valid     (cmd_valid),
        .cmd_is_mode   (cmd_is_mode),
        .cmd_code      (cmd_code),
        .live_tf       (live_tf),
        .live_ssf      (live_ssf),
        .live_bits     (live_bits),
        .pol_en_n      (pol_en_n),
        .pol_upd_n     (pol_upd_n),
        .pol_next_n    (pol_next_n),
        .pol_bitkeep_n (pol_bitkeep_n),
        .dbc_acc_n     (dbc_acc_n),
        .rep_tf        (rep_tf),
        .rep_ssf       (rep_ssf),
        .rep_dbca      (rep_dbca),
        .inh_tf        (inh_tf),
        .bits_o        (bits_q)
    );

    stflag_merr_window #(.WIN_CYC(ME_WIN_CYC)) u_merr (
        .clk      (clk),
        .rst_n    (rst_n),
        .incmd_n  (incmd_n),
        .merr_req (merr_req),
        .me_o     (sw_me)
    );

    assign sw_tf   = rep_tf & ~inh_tf;
    assign sw_ssf  = rep_ssf;
    assign sw_dbca = rep_dbca;
    assign bw_txto = bits_q[2];
    assign bw_hsf  = bits_q[1];
    assign bw_ltf  = bits_q[0];

    // R4
    inhibit_masks_tf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_is_mode && cmd_code == MC_INH) |=> !sw_tf);

    // R11
    dbca_follows_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dbc_acc_n) |=> !sw_dbca);

endmodule

// File: tb/stflag_policy_tb.sv
module stflag_policy_tb;
    localparam int WIN = 125;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 0, cmd_is_mode = 0;
    logic [4:0] cmd_code = '0;
    logic ss_err_n = 1, hs_fail = 0, lt_fail = 0, tx_timeout = 0, selftest_fail = 0, addr_par_err = 0;
    logic pol_en_n = 1, pol_upd_n = 1, pol_next_n = 1, pol_bitkeep_n = 1;
    logic incmd_n = 1, merr_req = 0, dbc_acc_n = 1;
    logic sw_tf, sw_ssf, sw_me, sw_dbca, bw_txto, bw_hsf, bw_ltf;

    int nchk = 0, nfail = 0, cyc = 0;
    bit run = 0;

    always #2 clk = ~clk;

    stflag_policy #(.ME_WIN_CYC(WIN)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_mode(cmd_is_mode),
        .cmd_code(cmd_code), .ss_err_n(ss_err_n), .hs_fail(hs_fail), .lt_fail(lt_fail),
        .tx_timeout(tx_timeout), .selftest_fail(selftest_fail), .addr_par_err(addr_par_err),
        .pol_en_n(pol_en_n), .pol_upd_n(pol_upd_n), .pol_next_n(pol_next_n),
        .pol_bitkeep_n(pol_bitkeep_n), .incmd_n(incmd_n), .merr_req(merr_req),
        .dbc_acc_n(dbc_acc_n), .sw_tf(sw_tf), .sw_ssf(sw_ssf), .sw_me(sw_me),
        .sw_dbca(sw_dbca), .bw_txto(bw_txto), .bw_hsf(bw_hsf), .bw_ltf(bw_ltf)
    );

    // behavioural reference model
    logic m_tf = 0, m_ssf = 0, m_rtf = 0, m_rssf = 0, m_dbca = 0, m_inh = 0, m_me = 0;
    logic [2:0] m_bits = '0;
    int m_phase = 0;   // 0 nothing pending, 1 new fault, 2 reported in next reply
    int m_cnt = 0;
    logic m_pinc = 1, m_pmerr = 0;
    logic c_lt, c_ls, c_ev, c_at, c_as, c_q, c_b, c_r;
    logic [2:0] c_lb, c_ab;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tf = 0; m_ssf = 0; m_rtf = 0; m_rssf = 0; m_dbca = 0; m_inh = 0; m_me = 0;
            m_bits = 0; m_phase = 0; m_cnt = 0; m_pinc = 1; m_pmerr = 0;
        end else begin
            c_lt = lt_fail | tx_timeout | selftest_fail | addr_par_err;
            c_ls = !ss_err_n | hs_fail;
            c_lb = {tx_timeout, hs_fail, lt_fail};
            c_ev = c_lt | c_ls;
            c_at = m_tf | c_lt; c_as = m_ssf | c_ls; c_ab = m_bits | c_lb;
            c_q = cmd_is_mode && (cmd_code == 5'b00010 || cmd_code == 5'b10010);
            c_b = cmd_is_mode && cmd_code == 5'b10011;
            c_r = cmd_is_mode && cmd_code == 5'b01000;
            if (!cmd_valid) begin
                m_tf = c_at; m_ssf = c_as; m_bits = c_ab;
                if (c_ev) m_phase = 1;
            end else if (c_r) begin
                m_tf = 0; m_ssf = 0; m_bits = 0; m_rtf = 0; m_rssf = 0;
                m_phase = 0; m_inh = 0;
            end else begin
                if (pol_en_n) begin
                    m_rtf = c_at; m_rssf = c_as;
                    if (c_q) begin m_tf = c_at; m_ssf = c_as; m_bits = c_ab; end
                    else begin m_tf = c_lt; m_ssf = c_ls; m_bits = c_lb; m_phase = 0; end
                    if (c_ev) m_phase = 1;
                end else if (c_q) begin
                    if (!pol_upd_n && m_phase == 1) begin m_rtf = c_at; m_rssf = c_as; end
                    m_tf = c_at; m_ssf = c_as; m_bits = c_ab;
                    if (c_ev) m_phase = 1;
                end else if (c_b && !pol_bitkeep_n && m_phase == 1) begin
                    m_rtf = c_at; m_rssf = c_as;
                    m_tf = c_at; m_ssf = c_as; m_bits = c_ab;
                end else if (!pol_next_n && m_phase == 1) begin
                    m_rtf = c_at; m_rssf = c_as;
                    m_tf = c_at; m_ssf = c_as; m_bits = c_ab;
                    m_phase = c_ev ? 1 : 2;
                end else begin
                    m_rtf = c_lt; m_rssf = c_ls;
                    m_tf = c_lt; m_ssf = c_ls; m_bits = c_lb;
                    m_phase = c_ev ? 1 : 0;
                end
                if (cmd_is_mode && cmd_code == 5'b00110) m_inh = 1;
                if (cmd_is_mode && cmd_code == 5'b00111) m_inh = 0;
            end
            if (cmd_valid) m_dbca = !dbc_acc_n;
            if (m_pinc && !incmd_n) begin
                m_cnt = WIN; m_me = 0;
            end else begin
                if (!m_pmerr && merr_req && m_cnt > 0) m_me = 1;
                if (m_cnt > 0) m_cnt = m_cnt - 1;
            end
            m_pinc = incmd_n; m_pmerr = merr_req;
        end
    end

    always @(negedge clk) begin
        if (rst_n && run) begin
            logic [6:0] dv, ev;
            dv = {sw_tf, sw_ssf, sw_me, sw_dbca, bw_txto, bw_hsf, bw_ltf};
            ev = {m_rtf & ~m_inh, m_rssf, m_me, m_dbca, m_bits};
            nchk++;
            if (dv !== ev) begin
                nfail++;
                $display("FAIL R2/R12 per-cycle model actual=%b expected=%b", dv, ev);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected<=50000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic docmd(input logic mode, input logic [4:0] code);
        cmd_valid = 1; cmd_is_mode = mode; cmd_code = code;
        tick();
        cmd_valid = 0; cmd_is_mode = 0; cmd_code = '0;
    endtask

    // 0 loop test, 1 timeout, 2 self-test, 3 address parity, 4 handshake
    task automatic fault(input int which);
        case (which)
            0: lt_fail = 1;
            1: tx_timeout = 1;
            2: selftest_fail = 1;
            3: addr_par_err = 1;
            default: hs_fail = 1;
        endcase
        tick();
        lt_fail = 0; tx_timeout = 0; selftest_fail = 0; addr_par_err = 0; hs_fail = 0;
    endtask

    task automatic fall_incmd();
        incmd_n = 1; tick();
        incmd_n = 0; tick();
    endtask

    initial begin
        repeat (3) tick();
        rst_n = 1; run = 1;
        tick();
        // R1
        chk("R1 outputs after reset", |{sw_tf, sw_ssf, sw_me, sw_dbca, bw_txto, bw_hsf, bw_ltf}, 1'b0);

        // R2, R12
        fault(0); chk("R2 bw_ltf latch", bw_ltf, 1);
        fault(4); chk("R2 bw_hsf latch", bw_hsf, 1);
        fault(1); chk("R2 bw_txto latch", bw_txto, 1);
        chk("R12 sw_tf quiet between commands", sw_tf, 0);
        chk("R12 sw_ssf quiet between commands", sw_ssf, 0);

        // R5 legacy
        pol_upd_n = 0;  // ignored while pol_en_n high
        docmd(0, 5'd3);
        chk("R5 legacy tf shown", sw_tf, 1);
        chk("R5 legacy ssf shown", sw_ssf, 1);
        chk("R5 legacy bits reload", bw_ltf | bw_hsf | bw_txto, 0);
        docmd(0, 5'd3);
        chk("R5 legacy tf gone", sw_tf, 0);
        ss_err_n = 0;
        docmd(0, 5'd3); chk("R5 held cause shown", sw_ssf, 1);
        docmd(0, 5'd3); chk("R5 held cause persists", sw_ssf, 1);
        ss_err_n = 1;
        docmd(0, 5'd3); chk("R5 ended cause once more", sw_ssf, 1);
        docmd(0, 5'd3); chk("R5 ended cause cleared", sw_ssf, 0);
        pol_upd_n = 1;

        // R4 inhibit
        fault(2); docmd(1, 5'b00110); chk("R4 inhibit masks tf", sw_tf, 0);
        fault(2); docmd(1, 5'b00111); chk("R4 inhibit removed", sw_tf, 1);
        docmd(1, 5'b00110);
        fault(3); docmd(0, 5'd4); chk("R4 inhibit persists", sw_tf, 0);

        // R3 reset command
        fault(3); fault(0);
        docmd(1, 5'b01000);
        chk("R3 reset clears tf", sw_tf, 0);
        chk("R3 reset clears bits", bw_ltf, 0);
        fault(3); docmd(0, 5'd1); chk("R3 reset removes inhibit", sw_tf, 1);

        // R11
        dbc_acc_n = 0; docmd(0, 5'd2); chk("R11 dbca shown", sw_dbca, 1);
        dbc_acc_n = 1; docmd(0, 5'd2); chk("R11 dbca cleared", sw_dbca, 0);

        // R6 clear on every command
        pol_en_n = 0;
        fault(0); docmd(0, 5'd7);
        chk("R6 pulse fault not shown", sw_tf, 0);
        chk("R6 bits cleared", bw_ltf, 0);
        docmd(1, 5'b00010); chk("R6 query repeats reply", sw_tf, 0);
        ss_err_n = 0; docmd(0, 5'd7); chk("R6 live ssf shown", sw_ssf, 1);
        ss_err_n = 1; tick();
        docmd(1, 5'b10010); chk("R6 last-command query repeats", sw_ssf, 1);
        docmd(0, 5'd7); chk("R6 cleared after cause ends", sw_ssf, 0);

        // R7 status update
        pol_upd_n = 0;
        fault(1);
        docmd(1, 5'b00010); chk("R7 query shows tf", sw_tf, 1);
        docmd(1, 5'b10010); chk("R7 repeated query shows tf", sw_tf, 1);
        docmd(0, 5'd9);
        chk("R7 other command clears tf", sw_tf, 0);
        chk("R7 other command clears txto", bw_txto, 0);
        docmd(1, 5'b00010); chk("R7 stale query clean", sw_tf, 0);
        pol_upd_n = 1;

        // R8 next status
        pol_next_n = 0;
        fault(4);
        docmd(1, 5'b00010); chk("R8 query not shown", sw_ssf, 0);
        docmd(0, 5'd11);
        chk("R8 next reply shows ssf", sw_ssf, 1);
        chk("R8 hsf kept", bw_hsf, 1);
        docmd(1, 5'b10010); chk("R8 query repeats shown", sw_ssf, 1);
        docmd(0, 5'd11);
        chk("R8 following command clears", sw_ssf, 0);
        chk("R8 hsf cleared", bw_hsf, 0);
        pol_next_n = 1;

        // R9 keep across test-word query
        pol_bitkeep_n = 0;
        fault(0);
        docmd(1, 5'b00010);
        docmd(1, 5'b10011);
        chk("R9 ltf kept", bw_ltf, 1);
        chk("R9 tf kept", sw_tf, 1);
        docmd(0, 5'd4);
        chk("R9 other command clears ltf", bw_ltf, 0);
        pol_bitkeep_n = 1;
        fault(0); docmd(1, 5'b10011);
        chk("R9 strap high clears ltf", bw_ltf, 0);

        // R10 message error window
        fall_incmd();
        repeat (2) tick();
        merr_req = 1; tick(); merr_req = 0;
        chk("R10 early request sets me", sw_me, 1);
        fall_incmd();
        chk("R10 new fall clears me", sw_me, 0);
        repeat (WIN - 1) tick();
        merr_req = 1; tick(); merr_req = 0;
        chk("R10 last window cycle accepted", sw_me, 1);
        fall_incmd();
        repeat (WIN) tick();
        merr_req = 1; tick(); merr_req = 0;
        chk("R10 late request ignored", sw_me, 0);

        repeat (3) tick();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule